// File: doc/BRIEF.md
# Fundamental-Mode Flow-Table Emulator

This block runs a two-input, four-state asynchronous flow table as a clocked machine. On every clock edge it looks up the next state code from the present code and the applied input pair, and it loads that code. It keeps stepping until the looked-up code equals the present code, which means the total state (input, state) is stable. It then gives a one-cycle settled strobe.

While it steps, the block polices the fundamental-mode rules. An input may change only while the total state is stable, and only one input bit may change at a time. It also reports two kinds of trouble. A transition that needs both state bits to flip is a race. The block then tries each single-bit-first order through the table, and if the two orders come to rest in different codes the race is critical. A column in which no state is stable makes the machine oscillate, and the block detects this with a step limit. All of these flags stay set until reset.

The flow table is a parameter, so other tables can be loaded; its default is the table in R2.

Top module: `fm_flow_emulator`

## Requirements
- R1: A synchronous active-high `rst` loads state code 00 and clears `settled`, `osc_flag`, `mode_err`, `race_flag` and `crit_race`. The remembered previous input is taken as 00.
- R2: Each clock edge loads the table entry for the present code and input into `y_state` (`y_state[1]`=y1, `x_in[1]`=x1). The codes are Q0=00, Q1=01, Q2=11 and Q3=10. The default entries, listed by present code for input 00/01/11/10, are: 00→01/00/00/10, 01→01/01/01/10, 11→11/01/11/10, 10→01/01/00/10.
- R3: After reset or an input change, `settled` is high for exactly one cycle. That cycle follows the first edge at which the looked-up code equals the present code. A change into a column where the state is already stable pulses `settled` after the first edge; a one-step move pulses it after the second edge.
- R4: An input change in which both bits of `x_in` differ from the previous input sets `mode_err`.
- R5: An input change made while the previous total state is unstable sets `mode_err`, even if only one bit changes.
- R6: Any transition in which both state bits change sets `race_flag`.
- R7: On a race, the block walks the table from each single-bit-flipped code under the same input, for up to the step limit, and sets `crit_race` if the two walks end in different codes. The move from 10 with input 00 is critical. The move from 01 with input 10 is non-critical.
- R8: Once the machine has made STEP_LIMIT (default 4) moves since the last input change or reset, a further move sets `osc_flag` at that edge. Under the default table `osc_flag` never sets.
- R9: Each flag stays set until reset, even through later transitions that change only one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 2 | Input pair {x1, x2} |
| y_state | output | 2 | Present state code {y1, y2} |
| settled | output | 1 | One-cycle strobe when the machine reaches a stable total state |
| osc_flag | output | 1 | Sticky oscillation flag |
| mode_err | output | 1 | Sticky fundamental-mode violation flag |
| race_flag | output | 1 | Sticky race flag (two state bits changed) |
| crit_race | output | 1 | Sticky critical-race flag |

## Verification
The assertions compare the input with its value one edge earlier, so they assume `x_in` holds steady while `rst` is high. They also ignore the first edge after reset, where the design compares against 00 rather than the last sampled input. The stimulus keeps `x_in` at 00 through every reset. For legal steps it changes the input only on a falling edge, one bit at a time, after the strobe. Double-bit changes and early changes are made on purpose only in the tests for R4 and R5. A second instance with a modified table, in which one column has no stable state, drives R8.

// File: rtl/fm_pkg.sv
package fm_pkg;
    localparam int CODE_W  = 2;
    localparam int IN_W    = 2;
    localparam int ENTRIES = 1 << (CODE_W + IN_W);
    localparam int TBL_W   = ENTRIES * CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [IN_W-1:0]   in_t;
    typedef logic [TBL_W-1:0]  table_t;

    // Entry position: index {present code, input column}
    function automatic table_t put(table_t t, code_t s, in_t x, code_t n);
        table_t r;
        r = t;
        r[int'({s, x}) * CODE_W +: CODE_W] = n;
        return r;
    endfunction

    function automatic code_t lookup(table_t t, code_t s, in_t x);
        return t[int'({s, x}) * CODE_W +: CODE_W];
    endfunction

    // Default flow table, codes Q0=00 Q1=01 Q2=11 Q3=10
    function automatic table_t default_table();
        table_t t;
        t = '0;
        t = put(t, 2'b00, 2'b00, 2'b01);
        t = put(t, 2'b00, 2'b01, 2'b00);
        t = put(t, 2'b00, 2'b11, 2'b00);
        t = put(t, 2'b00, 2'b10, 2'b10);
        t = put(t, 2'b01, 2'b00, 2'b01);
        t = put(t, 2'b01, 2'b01, 2'b01);
        t = put(t, 2'b01, 2'b11, 2'b01);
        t = put(t, 2'b01, 2'b10, 2'b10);
        t = put(t, 2'b11, 2'b00, 2'b11);
        t = put(t, 2'b11, 2'b01, 2'b01);
        t = put(t, 2'b11, 2'b11, 2'b11);
        t = put(t, 2'b11, 2'b10, 2'b10);
        t = put(t, 2'b10, 2'b00, 2'b01);
        t = put(t, 2'b10, 2'b01, 2'b01);
        t = put(t, 2'b10, 2'b11, 2'b00);
        t = put(t, 2'b10, 2'b10, 2'b10);
        return t;
    endfunction
endpackage

// File: rtl/fm_next_state.sv
module fm_next_state
    import fm_pkg::*;
#(
    parameter table_t TBL = default_table()
) (
    input  code_t cur,
    input  in_t   x,
    output code_t nxt
);
    assign nxt = lookup(TBL, cur, x);
endmodule

// File: rtl/fm_settle_walk.sv
module fm_settle_walk
    import fm_pkg::*;
#(
    parameter table_t TBL   = default_table(),
    parameter int     DEPTH = 4
) (
    input  code_t start,
    input  in_t   x,
    output code_t rest
);
    code_t hop [DEPTH+1];

    assign hop[0] = start;

    // Unrolled chain of table lookups under a fixed input column
    for (genvar i = 0; i < DEPTH; i++) begin : g_hop
        fm_next_state #(.TBL(TBL)) u_step (
            .cur (hop[i]),
            .x   (x),
            .nxt (hop[i+1])
        );
    end

    assign rest = hop[DEPTH];
endmodule

// File: rtl/fm_race_judge.sv
module fm_race_judge
    import fm_pkg::*;
#(
    parameter table_t TBL   = default_table(),
    parameter int     DEPTH = 4
) (
    input  code_t cur,
    input  in_t   x,
    input  code_t nxt,
    output logic  is_race,
    output logic  is_critical
);
    code_t ends [CODE_W];

    // One walk per state bit, that bit flipping first
    for (genvar b = 0; b < CODE_W; b++) begin : g_order
        code_t first_hop;
        assign first_hop = cur ^ code_t'(1 << b);
        fm_settle_walk #(.TBL(TBL), .DEPTH(DEPTH)) u_walk (
            .start (first_hop),
            .x     (x),
            .rest  (ends[b])
        );
    end

    assign is_race     = $countones(nxt ^ cur) > 1;
    assign is_critical = is_race && (ends[0] != ends[1]);
endmodule

// File: rtl/fm_flow_emulator.sv
module fm_flow_emulator
    import fm_pkg::*;
#(
    parameter table_t FLOW_TABLE = default_table(),
    parameter int     STEP_LIMIT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] x_in,
    output logic [1:0] y_state,
    output logic       settled,
    output logic       osc_flag,
    output logic       mode_err,
    output logic       race_flag,
    output logic       crit_race
);
    localparam int CNT_W = $clog2(STEP_LIMIT + 1);

    typedef struct packed {
        code_t            state;
        in_t              x_prev;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             settled;
        logic             osc;
        logic             mode;
        logic             race;
        logic             crit;
    } regs_t;

    regs_t r_q, r_d;
    code_t step_nxt;
    code_t hold_nxt;
    logic  race_now;
    logic  crit_now;

    fm_next_state #(.TBL(FLOW_TABLE)) u_step (
        .cur (r_q.state),
        .x   (x_in),
        .nxt (step_nxt)
    );

    // Stability of the total state under the previously applied input
    fm_next_state #(.TBL(FLOW_TABLE)) u_hold (
        .cur (r_q.state),
        .x   (r_q.x_prev),
        .nxt (hold_nxt)
    );

    fm_race_judge #(.TBL(FLOW_TABLE), .DEPTH(STEP_LIMIT)) u_race (
        .cur         (r_q.state),
        .x           (x_in),
        .nxt         (step_nxt),
        .is_race     (race_now),
        .is_critical (crit_now)
    );

    always_comb begin
        logic chg;
        logic moving;
        logic active;
        r_d    = r_q;
        chg    = x_in != r_q.x_prev;
        moving = step_nxt != r_q.state;
        active = chg || r_q.busy;

        r_d.state   = step_nxt;
        r_d.x_prev  = x_in;
        r_d.busy    = active && moving;
        r_d.settled = active && !moving;

        if (chg && ((hold_nxt != r_q.state) || ($countones(x_in ^ r_q.x_prev) > 1))) begin
            r_d.mode = 1'b1;
        end

        if (!moving) begin
            r_d.cnt = '0;
        end else if (chg) begin
            r_d.cnt = CNT_W'(1);
        end else if (r_q.cnt >= CNT_W'(STEP_LIMIT)) begin
            r_d.osc = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end

        if (moving && race_now) begin
            r_d.race = 1'b1;
        end
        if (moving && crit_now) begin
            r_d.crit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.busy  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign y_state   = r_q.state;
    assign settled   = r_q.settled;
    assign osc_flag  = r_q.osc;
    assign mode_err  = r_q.mode;
    assign race_flag = r_q.race;
    assign crit_race = r_q.crit;
endmodule

// File: rtl/fm_flow_emulator_chk.sv
module fm_flow_emulator_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] x_in,
    input logic [1:0] y_state,
    input logic       settled,
    input logic       osc_flag,
    input logic       mode_err,
    input logic       race_flag,
    input logic       crit_race
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (y_state == 2'b00 && !settled && !osc_flag && !mode_err && !race_flag && !crit_race));

    // R4
    double_input_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $countones(x_in ^ $past(x_in)) > 1) |=> mode_err);

    // R6
    two_bit_move_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $countones(y_state ^ $past(y_state)) == 2) |-> race_flag);

    // R7
    critical_is_race_chk: assert property (@(posedge clk) disable iff (rst)
        crit_race |-> race_flag);

    // R9
    sticky_mode_chk: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> mode_err);

    // R9
    sticky_race_chk: assert property (@(posedge clk) disable iff (rst)
        (race_flag && crit_race) |=> (race_flag && crit_race));

    // R9
    sticky_osc_chk: assert property (@(posedge clk) disable iff (rst)
        osc_flag |=> osc_flag);
endmodule

bind fm_flow_emulator fm_flow_emulator_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .x_in      (x_in),
    .y_state   (y_state),
    .settled   (settled),
    .osc_flag  (osc_flag),
    .mode_err  (mode_err),
    .race_flag (race_flag),
    .crit_race (crit_race)
);

// File: tb/fm_flow_emulator_test.sv
module fm_flow_emulator_test;
    import fm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    // Column 11 cycles 00->01->11->10->00 with no stable state
    function automatic table_t osc_table();
        table_t t;
        t = default_table();
        t = put(t, 2'b00, 2'b11, 2'b01);
        t = put(t, 2'b01, 2'b11, 2'b11);
        t = put(t, 2'b11, 2'b11, 2'b10);
        t = put(t, 2'b10, 2'b11, 2'b00);
        return t;
    endfunction

    // {reset first, x, expected state, race, crit, mode}
    localparam logic [7:0] VEC [10] = '{
        8'b1000_1000,
        8'b0101_0100,
        8'b0000_1110,
        8'b1010_1000,
        8'b0110_1000,
        8'b0101_0100,
        8'b0110_0100,
        8'b0010_0100,
        8'b0000_1100,
        8'b1110_1001
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] x = 2'b00;
    logic [1:0] x_osc = 2'b00;
    logic [1:0] st, st_o;
    logic       stl, osc, mode, race, crit;
    logic       stl_o, osc_o, mode_o, race_o, crit_o;
    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fm_flow_emulator uut (
        .clk(clk), .rst(rst), .x_in(x), .y_state(st), .settled(stl),
        .osc_flag(osc), .mode_err(mode), .race_flag(race), .crit_race(crit)
    );

    fm_flow_emulator #(.FLOW_TABLE(osc_table())) uut_osc (
        .clk(clk), .rst(rst), .x_in(x_osc), .y_state(st_o), .settled(stl_o),
        .osc_flag(osc_o), .mode_err(mode_o), .race_flag(race_o), .crit_race(crit_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; x = 2'b00; x_osc = 2'b00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: state and flags while reset is held
        repeat (2) @(negedge clk);
        chk("R1 state in reset", int'(st), 0);
        chk("R1 flags in reset", int'({stl, osc, mode, race, crit}), 0);

        // R2 R6 R7 R4 R8 R9: table walk
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][7]) do_reset();
            @(negedge clk);
            x = VEC[i][6:5];
            repeat (6) @(negedge clk);
            chk("R2 settled state", int'(st), int'(VEC[i][4:3]));
            chk("R6 race flag", int'(race), int'(VEC[i][2]));
            chk("R7 critical flag", int'(crit), int'(VEC[i][1]));
            chk("R4 mode flag", int'(mode), int'(VEC[i][0]));
            chk("R8 no oscillation on default table", int'(osc), 0);
        end

        // R1: reset clears sticky flags
        @(negedge clk);
        rst = 1'b1; x = 2'b00;
        @(negedge clk);
        chk("R1 state after reset", int'(st), 0);
        chk("R1 flags after reset", int'({stl, osc, mode, race, crit}), 0);

        // R3: one-step move, strobe after second edge
        do_reset();
        x = 2'b10;
        @(negedge clk);
        chk("R3 no strobe while moving", int'(stl), 0);
        @(negedge clk);
        chk("R3 strobe after settling", int'(stl), 1);
        @(negedge clk);
        chk("R3 strobe lasts one cycle", int'(stl), 0);

        // R3: already stable, strobe after first edge
        do_reset();
        x = 2'b01;
        @(negedge clk);
        chk("R3 immediate strobe", int'(stl), 1);
        @(negedge clk);
        chk("R3 immediate strobe ends", int'(stl), 0);
        chk("R4 single-bit legal change", int'(mode), 0);

        // R5: single-bit change before the post-reset move has settled
        @(negedge clk);
        rst = 1'b1; x = 2'b00;
        repeat (2) @(negedge clk);
        rst = 1'b0; x = 2'b01;
        repeat (3) @(negedge clk);
        chk("R5 change while unstable", int'(mode), 1);

        // R8: oscillating column on the second instance
        do_reset();
        x_osc = 2'b01;
        repeat (3) @(negedge clk);
        x_osc = 2'b11;
        repeat (4) @(negedge clk);
        chk("R8 no flag within limit", int'(osc_o), 0);
        @(negedge clk);
        chk("R8 flag on move past limit", int'(osc_o), 1);
        repeat (3) @(negedge clk);
        chk("R9 oscillation flag held", int'(osc_o), 1);
        chk("R3 no strobe while oscillating", int'(stl_o), 0);
        chk("R6 one-bit cycle is no race", int'(race_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule